// File: doc/BRIEF.md
# Bus-Mapped System Timer with Compare Match

This block is a free-running 32-bit system timer that a processor reaches over a minimal register bus: an address, a write strobe, write data and combinational read data. The count advances on a timer tick, a clock enable derived from the bus clock that stands in for a separate, slower timer clock. A compare register flags an event when the count reaches it. The event sets a sticky status bit. An enable register gates that bit onto the interrupt line, and software clears the bit by writing ones.

Software never sees the live count and never writes timer-side registers directly. Loading a new count, changing the compare value and capturing the count all go through a transfer channel. A channel is raised by a bus write, completes on the next timer tick and then settles for a fixed number of bus cycles. A per-channel busy flag in an access-status register shows the crossing in flight. A count read returns the last captured snapshot. A typical driver first writes the control register with the capture bit set. It then polls the read-busy flag and finally reads the count offset.

Top module: `tmr_os_timer`

## Requirements
- R1: After reset the compare register reads 0xFFFFFFFF. Count snapshot, status (0x14), interrupt enable (0x1C), control (0x20) and access status (0x24) all read 0, and `irq` is 0.
- R2: Control bit 0 enables counting. While it is set, the count grows by exactly one on each timer tick, one tick every TICK_DIV bus cycles, and wraps from 0xFFFFFFFF to 0. While it is clear, the count holds its value.
- R3: A control write (offset 0x20) with bit 1 set requests a snapshot and sets access-status bit 5 until the snapshot is valid. A read of offset 0x10 returns the latest snapshot, not the live count. Control bit 1 is not stored and reads back 0.
- R4: A write to offset 0x10 loads the count with the written value on the next timer tick, whether or not counting is enabled. Access-status bit 4 is set while that load is pending.
- R5: A write to offset 0x00 updates the compare register on the next timer tick. Until then, reads of 0x00 return the old value. Access-status bit 0 is set while that update is pending.
- R6: A pending flag is set from the cycle after its write. It clears exactly SETTLE_CYC bus cycles after the first tick that follows the write, so it stays high at least SETTLE_CYC+1 and at most TICK_DIV+SETTLE_CYC bus cycles.
- R7: Status bit 0 is set on an enabled timer tick where the count equals the compare register. No event is raised while counting is disabled. Status bits 3:1 always read 0.
- R8: Writing the status register clears each bit written as 1 and leaves bits written as 0. A match in the same cycle as a clear wins.
- R9: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R10: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the timer tick is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare-match interrupt request |

## Verification
Properties in the RTL check on every cycle that the count steps by one on an enabled tick and is frozen otherwise, and that the compare register changes only on its transfer strobe. They also check that a write always raises its channel's busy flag on the next cycle, that status bit 0 rises only after a timer tick, and that a clear with no competing match drops it. The bench scenarios are needed for what spans many cycles or needs values to be known. These include the window within which each busy flag clears, the snapshot staying frozen while the live count moves on, the number of ticks in a measured window, wrap-around, the cycle in which a match fires, and the interrupt masking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int STAT_W = 4;

    // Register offsets (software-visible map)
    localparam logic [ADDR_W-1:0] OFS_MATCH = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ASTAT = 6'h24;

    // Access-status bit positions
    localparam int AS_MWR_BIT = 0;
    localparam int AS_CWR_BIT = 4;
    localparam int AS_CRD_BIT = 5;

    // Control bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SNAP_BIT = 1;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_WAIT,
        CH_SETTLE
    } chan_state_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic crd_busy;
        logic cwr_busy;
        logic mwr_busy;
    } astat_t;

    function automatic logic wr_hit(input bus_req_t req, input logic [ADDR_W-1:0] ofs);
        return req.we && (req.addr == ofs);
    endfunction

    function automatic logic [DATA_W-1:0] pack_astat(input astat_t a);
        logic [DATA_W-1:0] v;
        v = '0;
        v[AS_CRD_BIT] = a.crd_busy;
        v[AS_CWR_BIT] = a.cwr_busy;
        v[AS_MWR_BIT] = a.mwr_busy;
        return v;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)               div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan
    import tmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int SETTLE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    output logic         busy,
    output logic         apply,
    output logic [W-1:0] data
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

    chan_state_t   state;
    logic [CW-1:0] cnt;
    logic [W-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CH_IDLE;
            cnt    <= '0;
            data_q <= '0;
        end else if (wr) begin
            state  <= CH_WAIT;
            cnt    <= '0;
            data_q <= wdata;
        end else begin
            unique case (state)
                CH_WAIT: begin
                    if (tick) begin
                        state <= CH_SETTLE;
                        cnt   <= '0;
                    end
                end
                CH_SETTLE: begin
                    if (cnt == CNT_LAST) state <= CH_IDLE;
                    else                 cnt   <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy  = (state != CH_IDLE);
    assign apply = (state == CH_WAIT) && tick && !wr;
    assign data  = data_q;

    // R6: a write raises the pending flag on the next cycle
    p_wr_busy_r6: assert property (@(posedge clk) disable iff (rst) wr |=> busy);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    input  logic         cnt_load,
    input  logic [W-1:0] cnt_val,
    input  logic         m_load,
    input  logic [W-1:0] m_val,
    input  logic         snap_take,
    output logic [W-1:0] count,
    output logic [W-1:0] match,
    output logic [W-1:0] snap,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst)                count <= '0;
        else if (cnt_load)      count <= cnt_val;
        else if (tick && en)    count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         match <= '1;
        else if (m_load) match <= m_val;
    end

    always_ff @(posedge clk) begin
        if (rst)            snap <= '0;
        else if (snap_take) snap <= count;
    end

    assign hit = tick && en && (count == match);

    // R2: enabled tick without load advances by one (wraps naturally)
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && en && !cnt_load) |=> (count == $past(count) + 1'b1));
    // R2: no tick and no load keeps the count frozen
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_load && !(tick && en)) |=> $stable(count));
    // R5: compare register only changes on its transfer strobe
    p_match_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !m_load |=> $stable(match));

endmodule

// File: rtl/tmr_os_timer.sv
module tmr_os_timer
    import tmr_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    bus_req_t req;
    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    logic tick;

    tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    // Software-side registers
    logic              en_q;
    logic              ien_q;
    logic [STAT_W-1:0] status_q;

    // Transfer channels
    logic              m_busy, m_apply;
    logic [DATA_W-1:0] m_data;
    logic              c_busy, c_apply;
    logic [DATA_W-1:0] c_data;
    logic              s_busy, s_apply;
    logic [0:0]        s_data;

    logic wr_match, wr_count, wr_snap, wr_stat;
    assign wr_match = wr_hit(req, OFS_MATCH);
    assign wr_count = wr_hit(req, OFS_COUNT);
    assign wr_snap  = wr_hit(req, OFS_CTRL) && req.wdata[CTRL_SNAP_BIT];
    assign wr_stat  = wr_hit(req, OFS_STAT);

    tmr_xfer_chan #(.W(DATA_W), .SETTLE(SETTLE_CYC)) u_mchan (
        .clk(clk), .rst(rst), .wr(wr_match), .wdata(req.wdata), .tick(tick),
        .busy(m_busy), .apply(m_apply), .data(m_data)
    );

    tmr_xfer_chan #(.W(DATA_W), .SETTLE(SETTLE_CYC)) u_cchan (
        .clk(clk), .rst(rst), .wr(wr_count), .wdata(req.wdata), .tick(tick),
        .busy(c_busy), .apply(c_apply), .data(c_data)
    );

    tmr_xfer_chan #(.W(1), .SETTLE(SETTLE_CYC)) u_schan (
        .clk(clk), .rst(rst), .wr(wr_snap), .wdata(req.wdata[CTRL_SNAP_BIT]), .tick(tick),
        .busy(s_busy), .apply(s_apply), .data(s_data)
    );

    logic [DATA_W-1:0] count, match, snap;
    logic              hit;

    tmr_count_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (en_q),
        .cnt_load (c_apply),
        .cnt_val  (c_data),
        .m_load   (m_apply),
        .m_val    (m_data),
        .snap_take(s_apply && s_data[0]),
        .count    (count),
        .match    (match),
        .snap     (snap),
        .hit      (hit)
    );

    logic [STAT_W-1:0] clr_mask, set_mask;
    assign clr_mask = wr_stat ? req.wdata[STAT_W-1:0] : '0;
    assign set_mask = {{(STAT_W-1){1'b0}}, hit};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            ien_q    <= 1'b0;
            status_q <= '0;
        end else begin
            if (wr_hit(req, OFS_CTRL)) en_q  <= req.wdata[CTRL_EN_BIT];
            if (wr_hit(req, OFS_IEN))  ien_q <= req.wdata[0];
            status_q <= (status_q & ~clr_mask) | set_mask;
        end
    end

    astat_t astat;
    assign astat = '{crd_busy: s_busy, cwr_busy: c_busy, mwr_busy: m_busy};

    always_comb begin
        unique case (req.addr)
            OFS_MATCH: bus_rdata = match;
            OFS_COUNT: bus_rdata = snap;
            OFS_STAT:  bus_rdata = {{(DATA_W-STAT_W){1'b0}}, status_q};
            OFS_IEN:   bus_rdata = {{(DATA_W-1){1'b0}}, ien_q};
            OFS_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
            OFS_ASTAT: bus_rdata = pack_astat(astat);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = status_q[0] && ien_q;

    // R7: a match event only appears after a timer tick
    p_stat_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[0]) |-> $past(tick));
    // R8: a clear of bit 0 without a competing match drops it
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && req.wdata[0] && !hit) |=> !status_q[0]);
    // R7: upper status bits are never raised
    p_stat_upper_r7: assert property (@(posedge clk) disable iff (rst)
        status_q[STAT_W-1:1] == '0);

endmodule

// File: tb/test_tmr_os_timer.sv
module test_tmr_os_timer;
    import tmr_pkg::*;

    localparam int TICK_DIV   = 4;
    localparam int SETTLE_CYC = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    always #10 clk = ~clk;

    tmr_os_timer #(.TICK_DIV(TICK_DIV), .SETTLE_CYC(SETTLE_CYC)) i_tmr_os_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic              is_irq;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic [DATA_W-1:0] mask;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic req = 1'b0;
    logic done = 1'b0;

    // Monitor: pops expected items and compares away from the clock edge
    exp_t        m_e;
    logic [31:0] m_act;
    always @(negedge clk) begin
        if (req && q.size() > 0) begin
            m_e   = q.pop_front();
            m_act = m_e.is_irq ? {31'b0, irq} : bus_rdata;
            n_vec++;
            if ((m_act & m_e.mask) !== (m_e.exp & m_e.mask)) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", m_e.tag, m_act & m_e.mask, m_e.exp & m_e.mask);
            end
            req = 1'b0;
        end
    end

    // Driver tasks
    task automatic chk(input logic is_irq, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] exp, input logic [DATA_W-1:0] mask,
                       input string tag);
        exp_t e;
        bus_addr = a;
        e.is_irq = is_irq; e.addr = a; e.exp = exp; e.mask = mask; e.tag = tag;
        q.push_back(e);
        req = 1'b1;
        wait (req == 1'b0);
    endtask

    task automatic chk_rng(input longint v, input longint lo, input longint hi, input string tag);
        n_vec++;
        if (v < lo || v > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, v, lo, hi);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wait_idle(input logic [DATA_W-1:0] m);
        bus_addr = OFS_ASTAT;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if ((bus_rdata & m) == '0) break;
        end
    endtask

    task automatic snapshot(output logic [DATA_W-1:0] v);
        wr(OFS_CTRL, 32'h2);
        wait_idle(32'h20);
        rd(OFS_COUNT, v);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a_v, b_v, c_v;
        int k;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        chk(0, OFS_MATCH, 32'hFFFF_FFFF, '1, "R1 match reset");
        chk(0, OFS_COUNT, 32'h0, '1, "R1 snapshot reset");
        chk(0, OFS_STAT,  32'h0, '1, "R1 status reset");
        chk(0, OFS_IEN,   32'h0, '1, "R1 ien reset");
        chk(0, OFS_CTRL,  32'h0, '1, "R1 ctrl reset");
        chk(0, OFS_ASTAT, 32'h0, '1, "R1 astat reset");
        chk(1, '0, 32'h0, '1, "R1 irq reset");
        // R10 unmapped offset
        chk(0, 6'h08, 32'h0, '1, "R10 unmapped read");

        // R4/R6 count load through pending channel, latency window
        wr(OFS_COUNT, 32'd100);
        bus_addr = OFS_ASTAT;
        k = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bus_rdata[AS_CWR_BIT]) k++;
            else break;
        end
        chk_rng(k, SETTLE_CYC + 1, TICK_DIV + SETTLE_CYC, "R6 count-write busy duration");

        // R3 snapshot request with counting disabled
        wr(OFS_CTRL, 32'h2);
        chk(0, OFS_ASTAT, 32'h20, 32'h20, "R3 read busy set");
        wait_idle(32'h20);
        chk(0, OFS_COUNT, 32'd100, '1, "R4 loaded value via snapshot");
        chk(0, OFS_CTRL, 32'h0, '1, "R3 snapshot bit not stored");

        // R5 match write pending
        wr(OFS_MATCH, 32'd105);
        chk(0, OFS_MATCH, 32'hFFFF_FFFF, '1, "R5 old match while pending");
        chk(0, OFS_ASTAT, 32'h1, 32'h1, "R5 match busy set");
        wait_idle(32'h1);
        chk(0, OFS_MATCH, 32'd105, '1, "R5 match updated");
        chk(0, OFS_STAT, 32'h0, '1, "R7 no event yet");

        // R7 match timing: enable at count 100, match on sixth enabled tick
        wr(OFS_CTRL, 32'h1);
        bus_addr = OFS_STAT;
        k = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            k++;
            if (bus_rdata[0]) break;
        end
        chk_rng(k, 5 * TICK_DIV + 2, 6 * TICK_DIV + 1, "R7 match event cycle");
        chk(1, '0, 32'h0, '1, "R9 irq masked by ien=0");
        wr(OFS_IEN, 32'h1);
        chk(1, '0, 32'h1, '1, "R9 irq asserted");
        wr(OFS_IEN, 32'h0);
        chk(1, '0, 32'h0, '1, "R9 irq masked again");
        wr(OFS_IEN, 32'h1);

        // R8 write-one-to-clear
        wr(OFS_STAT, 32'hE);
        chk(0, OFS_STAT, 32'h1, '1, "R8 zero bit keeps event");
        wr(OFS_STAT, 32'hF);
        chk(0, OFS_STAT, 32'h0, '1, "R8 clear all");
        chk(1, '0, 32'h0, '1, "R9 irq drops after clear");

        // R3 snapshot frozen while count runs
        wr(OFS_CTRL, 32'h3);
        wait_idle(32'h20);
        rd(OFS_COUNT, a_v);
        chk_rng(a_v, 106, 200, "R2 count moved past match");
        repeat (40) @(negedge clk);
        chk(0, OFS_COUNT, a_v, '1, "R3 snapshot not live");

        // R2 tick rate over a measured window
        wr(OFS_CTRL, 32'h0);
        snapshot(b_v);
        wr(OFS_CTRL, 32'h1);
        repeat (40) @(posedge clk);
        wr(OFS_CTRL, 32'h0);
        snapshot(c_v);
        chk_rng(c_v - b_v, 9, 11, "R2 ticks in 41-cycle window");
        repeat (40) @(negedge clk);
        snapshot(a_v);
        chk(0, OFS_COUNT, c_v, '1, "R2 count holds when disabled");

        // R7 no event while disabled even when count equals match
        wr(OFS_MATCH, c_v);
        wait_idle(32'h1);
        wr(OFS_STAT, 32'hF);
        repeat (40) @(negedge clk);
        chk(0, OFS_STAT, 32'h0, '1, "R7 no event when disabled");

        // R2 wrap-around
        wr(OFS_COUNT, 32'hFFFF_FFFE);
        wait_idle(32'h10);
        wr(OFS_CTRL, 32'h1);
        repeat (11) @(posedge clk);
        wr(OFS_CTRL, 32'h0);
        snapshot(a_v);
        chk_rng(a_v, 0, 3, "R2 wrap past all ones");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule